// File: doc/BRIEF.md
# 4B/5B Transmit Code-Group Encoder

This block sits on the transmit side of a 100 Mb/s twisted-pair physical layer, between the MAC's nibble-wide transmit interface and the scrambler. On every clock it takes one nibble together with its enable and error flags, and it puts out one registered 5-bit code-group. When no frame is being sent, it sends the idle code. At the start of a frame, the first two nibbles (the first preamble byte) are replaced by the start delimiter pair. When the enable drops, the frame is closed with the end delimiter pair.

A per-frame option adds one pad code-group. When that option is on and the MAC ends a frame after an odd number of nibbles, the encoder keeps the frame open for one more cycle and sends the transmit-error code in that slot. The receiving MAC can then tell that the odd length was detected. Scrambling, line coding and serialization take place downstream of this block.

Top module: `tx4b5b_encoder`

## Requirements
- R1: A data nibble N (0x0..0xF) sent inside a frame with the error flag low is encoded as follows: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R2: When the enable rises while no frame is active, the output is J = 11000 and then K = 10001. These two slots replace the first two nibbles, whatever their values or error flags.
- R3: On the first cycle the enable is sampled low inside a frame (with no pad due), the output is T = 01101 and then R = 00111.
- R4: Between frames, and on every cycle after R while the enable stays low, the output is IDLE = 11111.
- R5: When the enable falls after an odd number of nibbles and error forwarding is on, the output is H = 00100, followed by T and then R.
- R6: A nibble sent inside a frame with the error flag high is encoded as H = 00100.
- R7: When error forwarding is off, the enable falling after an odd number of nibbles is followed directly by T and R, with no pad code-group.
- R8: Frame parity counts the J and K slots as two nibbles. A frame in which the enable was high for N cycles is padded only when N is odd.
- R9: The enable is ignored while T or R is being sent. If the enable is high after R, J follows on the very next cycle, and the nibbles sampled during T or R are discarded.
- R10: A synchronous active-low reset makes the output IDLE on the next clock edge and cancels any frame in progress.
- R11: Each code-group is registered. Inputs sampled at a clock edge appear on the output after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_en | input | 1 | Frame enable from the MAC |
| tx_er | input | 1 | Transmit error flag from the MAC |
| txd | input | 4 | Transmit nibble |
| err_fwd_en | input | 1 | Enables the odd-length pad |
| code_o | output | 5 | Registered 5-bit code-group |

## Verification
Every code-group depends on the inputs sampled at one rising edge and appears on the output right after that edge. The tail of a frame is fixed: the pad (if any), T and R come on consecutive cycles after the edge that first samples the enable low. The bench applies new inputs on the falling edge, and it predicts the code-group for those inputs from a cycle-level model built from the requirements. It then compares the output on the following falling edge, half a period after the register has updated. This keeps every comparison exactly one edge after its stimulus, including the cycles inside a delimiter or pad tail, during which inputs are ignored.

// File: rtl/tx4b5b_pkg.sv
package tx4b5b_pkg;
    localparam int NIB_W = 4;
    localparam int CG_W  = 5;

    typedef logic [NIB_W-1:0] nib_t;
    typedef logic [CG_W-1:0]  cg_t;

    localparam cg_t CG_IDLE  = 5'b11111;
    localparam cg_t CG_SSD_1 = 5'b11000;
    localparam cg_t CG_SSD_2 = 5'b10001;
    localparam cg_t CG_ESD_1 = 5'b01101;
    localparam cg_t CG_ESD_2 = 5'b00111;
    localparam cg_t CG_ERR   = 5'b00100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SECOND,
        ST_BODY,
        ST_CLOSE1,
        ST_CLOSE2
    } fr_state_e;

    typedef struct packed {
        fr_state_e st;
        logic      odd;
        cg_t       code;
    } fr_regs_t;
endpackage

// File: rtl/tx4b5b_nib_lut.sv
module tx4b5b_nib_lut
    import tx4b5b_pkg::*;
(
    input  nib_t nib_i,
    output cg_t  cg_o
);
    always_comb begin
        unique case (nib_i)
            4'h0: cg_o = 5'b11110;
            4'h1: cg_o = 5'b01001;
            4'h2: cg_o = 5'b10100;
            4'h3: cg_o = 5'b10101;
            4'h4: cg_o = 5'b01010;
            4'h5: cg_o = 5'b01011;
            4'h6: cg_o = 5'b01110;
            4'h7: cg_o = 5'b01111;
            4'h8: cg_o = 5'b10010;
            4'h9: cg_o = 5'b10011;
            4'hA: cg_o = 5'b10110;
            4'hB: cg_o = 5'b10111;
            4'hC: cg_o = 5'b11010;
            4'hD: cg_o = 5'b11011;
            4'hE: cg_o = 5'b11100;
            default: cg_o = 5'b11101;
        endcase
    end
endmodule

// File: rtl/tx4b5b_frame_fsm.sv
module tx4b5b_frame_fsm
    import tx4b5b_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic tx_er,
    input  logic fwd_en,
    input  cg_t  data_cg,
    output cg_t  code_o
);
    fr_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.st)
            ST_IDLE: begin
                if (tx_en) begin
                    regs_d.code = CG_SSD_1;
                    regs_d.st   = ST_SECOND;
                end else begin
                    regs_d.code = CG_IDLE;
                end
            end
            ST_SECOND: begin
                regs_d.code = CG_SSD_2;
                regs_d.odd  = 1'b0;
                regs_d.st   = ST_BODY;
            end
            ST_BODY: begin
                if (tx_en) begin
                    regs_d.code = tx_er ? CG_ERR : data_cg;
                    regs_d.odd  = ~regs_q.odd;
                end else if (regs_q.odd && fwd_en) begin
                    regs_d.code = CG_ERR;
                    regs_d.st   = ST_CLOSE1;
                end else begin
                    regs_d.code = CG_ESD_1;
                    regs_d.st   = ST_CLOSE2;
                end
            end
            ST_CLOSE1: begin
                regs_d.code = CG_ESD_1;
                regs_d.st   = ST_CLOSE2;
            end
            ST_CLOSE2: begin
                regs_d.code = CG_ESD_2;
                regs_d.st   = ST_IDLE;
            end
            default: begin
                regs_d.code = CG_IDLE;
                regs_d.st   = ST_IDLE;
            end
        endcase
        if (!rst_n) begin
            regs_d.st   = ST_IDLE;
            regs_d.odd  = 1'b0;
            regs_d.code = CG_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign code_o = regs_q.code;

    // R10: reset drives idle out on the following edge
    p_reset_idle_r10: assert property (@(posedge clk)
        !rst_n |=> code_o == CG_IDLE);

    // R2: second delimiter half always follows the first
    p_ssd_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        code_o == CG_SSD_1 |=> code_o == CG_SSD_2);

    // R3: end delimiter halves are consecutive
    p_esd_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        code_o == CG_ESD_1 |=> code_o == CG_ESD_2);

    // R9: after the closing code only idle or a fresh start may follow
    p_after_close_r9: assert property (@(posedge clk) disable iff (!rst_n)
        code_o == CG_ESD_2 |=> (code_o == CG_IDLE || code_o == CG_SSD_1));

    // R5: odd-length close with forwarding on gives the pad code
    p_pad_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.st == ST_BODY && !tx_en && regs_q.odd && fwd_en)
        |=> code_o == CG_ERR ##1 code_o == CG_ESD_1);

    // R7: with forwarding off the close goes straight to the delimiter
    p_no_pad_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.st == ST_BODY && !tx_en && !fwd_en) |=> code_o == CG_ESD_1);

    // R6: flagged nibble in the body becomes the error code
    p_err_nibble_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.st == ST_BODY && tx_en && tx_er) |=> code_o == CG_ERR);
endmodule

// File: rtl/tx4b5b_encoder.sv
module tx4b5b_encoder
    import tx4b5b_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_en,
    input  logic       tx_er,
    input  logic [3:0] txd,
    input  logic       err_fwd_en,
    output logic [4:0] code_o
);
    cg_t lut_cg;
    cg_t fsm_cg;

    tx4b5b_nib_lut u_lut (
        .nib_i (nib_t'(txd)),
        .cg_o  (lut_cg)
    );

    tx4b5b_frame_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_en   (tx_en),
        .tx_er   (tx_er),
        .fwd_en  (err_fwd_en),
        .data_cg (lut_cg),
        .code_o  (fsm_cg)
    );

    assign code_o = fsm_cg;
endmodule

// File: tb/tx4b5b_encoder_tb.sv
module tx4b5b_encoder_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       tx_er = 1'b0;
    logic [3:0] txd = 4'h0;
    logic       err_fwd_en = 1'b0;
    logic [4:0] code_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tx4b5b_encoder dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .tx_er      (tx_er),
        .txd        (txd),
        .err_fwd_en (err_fwd_en),
        .code_o     (code_o)
    );

    localparam logic [4:0] E_I = 5'b11111, E_J = 5'b11000, E_K = 5'b10001;
    localparam logic [4:0] E_T = 5'b01101, E_R = 5'b00111, E_H = 5'b00100;

    // reference model state (built from the requirements)
    bit         m_busy;
    int         m_pos;
    logic [4:0] m_tail[$];

    function automatic logic [4:0] enc_nib(input logic [3:0] n);
        logic [4:0] tbl [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                                 5'b01010, 5'b01011, 5'b01110, 5'b01111,
                                 5'b10010, 5'b10011, 5'b10110, 5'b10111,
                                 5'b11010, 5'b11011, 5'b11100, 5'b11101};
        return tbl[n];
    endfunction

    function automatic logic [4:0] ref_step(input bit en, input bit er,
                                            input logic [3:0] d, input bit fwd);
        logic [4:0] o;
        if (m_tail.size() > 0) begin
            o = m_tail.pop_front();
        end else if (!m_busy) begin
            if (en) begin o = E_J; m_busy = 1; m_pos = 1; end
            else o = E_I;
        end else if (m_pos == 1) begin
            o = E_K; m_pos = 2;
        end else if (en) begin
            o = er ? E_H : enc_nib(d); m_pos++;
        end else begin
            m_busy = 0;
            if ((m_pos % 2 == 1) && fwd) begin
                o = E_H; m_tail.push_back(E_T); m_tail.push_back(E_R);
            end else begin
                o = E_T; m_tail.push_back(E_R);
            end
        end
        return o;
    endfunction

    function automatic string tag_of(input logic [4:0] e);
        case (e)
            E_I: return "R4";
            E_J, E_K: return "R2";
            E_T, E_R: return "R3";
            E_H: return "R6";
            default: return "R1";
        endcase
    endfunction

    // one cycle: drive at falling edge, check at the next falling edge (R11)
    task automatic cyc(input bit en, input bit er, input logic [3:0] d,
                       input bit fwd, input string tag);
        logic [4:0] exp;
        tx_en = en; tx_er = er; txd = d; err_fwd_en = fwd;
        exp = ref_step(en, er, d, fwd);
        @(posedge clk);
        @(negedge clk);
        n_run++;
        if (code_o !== exp) begin
            n_fail++;
            $display("FAIL %s/%s R11: code_o=%b expected=%b", tag, tag_of(exp), code_o, exp);
        end
    endtask

    task automatic frame(input int n, input int gap, input bit fwd,
                         input int er_at, input string tag);
        for (int i = 0; i < n; i++)
            cyc(1'b1, i == er_at, 4'($urandom_range(0, 15)), fwd, tag);
        for (int i = 0; i < gap; i++)
            cyc(1'b0, 1'b0, 4'h0, fwd, tag);
    endtask

    initial begin
        void'($urandom(32'd2024));
        m_busy = 0; m_pos = 0;
        // R10: reset state
        repeat (3) @(negedge clk);
        n_run++;
        if (code_o !== E_I) begin
            n_fail++;
            $display("FAIL R10: code_o=%b expected=%b", code_o, E_I);
        end
        rst_n = 1'b1;
        cyc(0, 0, 4'h0, 0, "R4");
        // R1: every nibble value in one frame
        cyc(1, 0, 4'h5, 0, "R2");
        cyc(1, 1, 4'h5, 0, "R2");
        for (int v = 0; v < 16; v++) cyc(1, 0, 4'(v), 0, "R1");
        cyc(0, 0, 4'h0, 0, "R3");
        cyc(0, 0, 4'h0, 0, "R3");
        cyc(0, 0, 4'h0, 0, "R4");
        // R5 R8: odd frame with forwarding, even frame with forwarding
        frame(7, 4, 1, -1, "R5");
        frame(8, 4, 1, -1, "R8");
        frame(3, 4, 1, -1, "R8");
        // R7: odd frame without forwarding
        frame(7, 4, 0, -1, "R7");
        // R6: error flag mid frame
        frame(9, 4, 0, 4, "R6");
        // R9: restart while the delimiter tail is still being sent
        frame(6, 1, 0, -1, "R9");
        frame(5, 1, 1, -1, "R9");
        frame(6, 3, 0, -1, "R9");
        // R10: reset in the middle of a frame
        frame(5, 0, 1, -1, "R10");
        rst_n = 1'b0; tx_en = 1'b1;
        @(posedge clk); @(negedge clk);
        n_run++;
        if (code_o !== E_I) begin
            n_fail++;
            $display("FAIL R10: code_o=%b expected=%b", code_o, E_I);
        end
        m_busy = 0; m_pos = 0; m_tail.delete();
        rst_n = 1'b1;
        cyc(0, 0, 4'h0, 0, "R10");
        // random frames
        for (int f = 0; f < 400; f++)
            frame($urandom_range(2, 30), $urandom_range(1, 5), 1'($urandom_range(0, 1)),
                  ($urandom_range(0, 9) == 0) ? $urandom_range(2, 20) : -1, "RND");
        frame(0, 6, 0, -1, "R4");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not end");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule